// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Direct-Mapped Cache

This block is a small direct-mapped data cache that begins its array read before address translation has finished. The set index and the byte offset come from the untranslated page-offset bits of the virtual address. The TLB resolves the virtual page number in parallel. One cycle later the translated physical page number arrives at the block and is compared with the physical tag stored in the selected line. The block then reports a hit with the addressed byte, a cache miss, or a translation miss.

Line fills arrive on a separate refill port, which writes a whole block together with its tag and valid bit. In the default configuration the page is 64 bytes, so the 6-bit page offset holds exactly the 2 block-offset bits and the 4 index bits. The physical tag is then the same as the physical page number, and every virtual index is also the physical index. Write policy and the backing memory belong to the surrounding logic.

Top module: `vipt_cache`

## Requirements
- R1: A lookup takes its line index from page-offset bits [5:2] and its byte offset from bits [1:0]. The physical tag is the 6-bit physical page number. Physical address 0x354 therefore selects line 5 with tag 0x0D, and 0xA20 selects line 8 with tag 0x28.
- R2: After reset every line is invalid. respValid stays low until a lookup has completed, and the first lookup of any line reports respMiss.
- R3: When reqValid is sampled at clock edge N, the TLB result (tlbHit, tlbPpn) is sampled at edge N+1. The response is visible from edge N+1 until edge N+2.
- R4: If the line is valid, its stored tag equals tlbPpn and tlbHit is 1, the block raises respHit. respData then returns byte k of the block, where byte k occupies bits [8k+7:8k] of the refill word.
- R5: If tlbHit is 1 and the line is invalid or holds a different tag, the block raises respMiss and respData is 0. A stored tag of 0x24 at line 8 misses for tag 0x28.
- R6: If tlbHit is 0 in the compare cycle, the block raises respTlbMiss. respHit and respMiss stay low and respData is 0, even when the stored tag matches.
- R7: A refill writes the 32-bit block, tag refillLine[9:4] and the valid bit into line refillLine[3:0]. Any earlier contents of that line are replaced.
- R8: While respValid is high, exactly one of respHit, respMiss and respTlbMiss is high. While respValid is low, all three are low.
- R9: A new lookup can be issued every cycle, and each one gets its own response in order.
- R10: A refill in the same cycle as a lookup of the same line is not seen by that lookup. Lookups issued in later cycles see it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Lookup request |
| reqPageOff | input | 6 | Untranslated page-offset bits of the virtual address |
| tlbHit | input | 1 | TLB translation valid, one cycle after the request |
| tlbPpn | input | 6 | Translated physical page number, one cycle after the request |
| refillValid | input | 1 | Write a line |
| refillLine | input | 10 | Physical block address of the fill (tag and index) |
| refillData | input | 32 | Fill block, byte 0 in the low bits |
| respValid | output | 1 | Response present |
| respHit | output | 1 | Cache hit |
| respMiss | output | 1 | Cache miss with valid translation |
| respTlbMiss | output | 1 | Translation missed, cache result suppressed |
| respData | output | 8 | Addressed byte on a hit, else 0 |

## Verification
The block is tried with directed lookups that use the two worked addresses. These show whether the index and tag are taken from the right bits, and whether a line holding tag 0x24 is told apart from a request for tag 0x28. A TLB miss against a matching line separates suppression from a plain tag compare. Back-to-back requests and a refill that collides with a lookup of the same line expose any pipeline skew and any read-after-write ordering error. A long pseudo-random mix of lookups, refills and TLB outcomes over a small tag range is then compared with a behavioural reference model on every cycle, so that hits, aliasing tags and line replacement all occur many times.

// File: rtl/vipt_cache_pkg.sv
package vipt_cache_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic arrayRead;   // capture the indexed line into the compare stage
    logic arrayWrite;  // write a refilled line
    logic dataLoad;    // register the selected byte as hit data
  } viptStrobes_t;

endpackage

// File: rtl/vipt_cache_ctrl.sv
module vipt_cache_ctrl
  import vipt_cache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         refillValid,
  input  logic         tlbHit,
  input  logic         tagMatch,
  output viptStrobes_t strobes,
  output logic         respValid,
  output logic         respHit,
  output logic         respMiss,
  output logic         respTlbMiss
);

  logic stage1Valid;
  logic hitNow;

  assign hitNow = stage1Valid && tlbHit && tagMatch;

  always_comb begin
    strobes.arrayRead  = reqValid;
    strobes.arrayWrite = refillValid;
    strobes.dataLoad   = hitNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1Valid <= 1'b0;
      respValid   <= 1'b0;
      respHit     <= 1'b0;
      respMiss    <= 1'b0;
      respTlbMiss <= 1'b0;
    end else begin
      stage1Valid <= reqValid;
      respValid   <= stage1Valid;
      respHit     <= hitNow;
      respMiss    <= stage1Valid && tlbHit && !tagMatch;
      respTlbMiss <= stage1Valid && !tlbHit;
    end
  end

  // R8: exactly one outcome per response
  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $countones({respHit, respMiss, respTlbMiss}) == 1);

  // R8: no outcome without a response
  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> !(respHit || respMiss || respTlbMiss));

  // R6: translation miss suppresses the cache result
  assert_tlb_suppress_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stage1Valid && !tlbHit) |=> (respTlbMiss && !respHit && !respMiss));

  // R3: a response follows a request by two edges
  assert_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(reqValid, 2));

  // R5: a cache miss needs a valid translation
  assert_miss_translated_R5: assert property (@(posedge clk) disable iff (!rstN)
    respMiss |-> $past(tlbHit));

endmodule

// File: rtl/vipt_cache_datapath.sv
module vipt_cache_datapath
  import vipt_cache_pkg::*;
#(
  parameter int PA_W        = 12,
  parameter int PAGE_OFF_W  = 6,
  parameter int LINES       = 16,
  parameter int BLOCK_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  viptStrobes_t                  strobes,
  input  logic [PAGE_OFF_W-1:0]         reqPageOff,
  input  logic [PA_W-PAGE_OFF_W-1:0]    tlbPpn,
  input  logic [PA_W-$clog2(BLOCK_BYTES)-1:0] refillLine,
  input  logic [8*BLOCK_BYTES-1:0]      refillData,
  output logic                          tagMatch,
  output logic [7:0]                    respData
);

  localparam int OFF_W   = $clog2(BLOCK_BYTES);
  localparam int IDX_W   = $clog2(LINES);
  localparam int TAG_W   = PA_W - IDX_W - OFF_W;
  localparam int PPN_W   = PA_W - PAGE_OFF_W;
  localparam int EXTRA_W = PAGE_OFF_W - IDX_W - OFF_W;
  localparam int BLK_W   = 8 * BLOCK_BYTES;

  logic [LINES-1:0] lineValid;
  logic [TAG_W-1:0] tagArr  [LINES];
  logic [BLK_W-1:0] dataArr [LINES];

  logic [IDX_W-1:0] rdIdx;
  logic [IDX_W-1:0] wrIdx;
  logic [TAG_W-1:0] wrTag;

  logic             lineValidQ;
  logic [TAG_W-1:0] lineTagQ;
  logic [BLK_W-1:0] lineBlockQ;
  logic [OFF_W-1:0] byteOffQ;
  logic [TAG_W-1:0] reqTag;
  logic [7:0]       selByte;

  assign rdIdx = reqPageOff[OFF_W +: IDX_W];
  assign wrIdx = refillLine[IDX_W-1:0];
  assign wrTag = refillLine[IDX_W +: TAG_W];

  // Valid bits reset; tag and data storage behave as plain memory
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValid <= '0;
    end else if (strobes.arrayWrite) begin
      lineValid[wrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.arrayWrite) begin
      tagArr[wrIdx]  <= wrTag;
      dataArr[wrIdx] <= refillData;
    end
  end

  // Compare stage: line read while the TLB translates
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValidQ <= 1'b0;
      lineTagQ   <= '0;
      lineBlockQ <= '0;
      byteOffQ   <= '0;
    end else if (strobes.arrayRead) begin
      lineValidQ <= lineValid[rdIdx];
      lineTagQ   <= tagArr[rdIdx];
      lineBlockQ <= dataArr[rdIdx];
      byteOffQ   <= reqPageOff[OFF_W-1:0];
    end
  end

  // Physical tag of the request: page number plus any page-offset bits above the index
  generate
    if (EXTRA_W > 0) begin : g_tagExtra
      logic [EXTRA_W-1:0] extraQ;
      always_ff @(posedge clk) begin
        if (!rstN) extraQ <= '0;
        else if (strobes.arrayRead) extraQ <= reqPageOff[PAGE_OFF_W-1 -: EXTRA_W];
      end
      assign reqTag = {tlbPpn, extraQ};
    end else begin : g_tagPpn
      assign reqTag = tlbPpn[PPN_W-1:0];
    end
  endgenerate

  assign tagMatch = lineValidQ && (lineTagQ == reqTag);
  assign selByte  = lineBlockQ[8*byteOffQ +: 8];

  always_ff @(posedge clk) begin
    if (!rstN) respData <= '0;
    else if (strobes.dataLoad) respData <= selByte;
    else respData <= '0;
  end

  // R4: returned data only after a hit decision
  assert_data_on_hit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (respData != 8'd0) |-> $past(strobes.dataLoad));

endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_cache_pkg::*;
#(
  parameter int PA_W        = 12,
  parameter int PAGE_OFF_W  = 6,
  parameter int LINES       = 16,
  parameter int BLOCK_BYTES = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   reqValid,
  input  logic [PAGE_OFF_W-1:0]                  reqPageOff,
  input  logic                                   tlbHit,
  input  logic [PA_W-PAGE_OFF_W-1:0]             tlbPpn,
  input  logic                                   refillValid,
  input  logic [PA_W-$clog2(BLOCK_BYTES)-1:0]    refillLine,
  input  logic [8*BLOCK_BYTES-1:0]               refillData,
  output logic                                   respValid,
  output logic                                   respHit,
  output logic                                   respMiss,
  output logic                                   respTlbMiss,
  output logic [7:0]                             respData
);

  viptStrobes_t strobes;
  logic         tagMatch;

  vipt_cache_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .refillValid(refillValid),
    .tlbHit     (tlbHit),
    .tagMatch   (tagMatch),
    .strobes    (strobes),
    .respValid  (respValid),
    .respHit    (respHit),
    .respMiss   (respMiss),
    .respTlbMiss(respTlbMiss)
  );

  vipt_cache_datapath #(
    .PA_W       (PA_W),
    .PAGE_OFF_W (PAGE_OFF_W),
    .LINES      (LINES),
    .BLOCK_BYTES(BLOCK_BYTES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqPageOff(reqPageOff),
    .tlbPpn    (tlbPpn),
    .refillLine(refillLine),
    .refillData(refillData),
    .tagMatch  (tagMatch),
    .respData  (respData)
  );

endmodule

// File: tb/vipt_cache_tb_top.sv
module vipt_cache_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [5:0]  reqPageOff = '0;
  logic        tlbHit = 1'b0;
  logic [5:0]  tlbPpn = '0;
  logic        refillValid = 1'b0;
  logic [9:0]  refillLine = '0;
  logic [31:0] refillData = '0;
  logic        respValid, respHit, respMiss, respTlbMiss;
  logic [7:0]  respData;

  int checks = 0;
  int fails = 0;
  string curReq = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  vipt_cache dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPageOff(reqPageOff),
    .tlbHit(tlbHit), .tlbPpn(tlbPpn), .refillValid(refillValid),
    .refillLine(refillLine), .refillData(refillData), .respValid(respValid),
    .respHit(respHit), .respMiss(respMiss), .respTlbMiss(respTlbMiss),
    .respData(respData)
  );

  // Behavioural reference model
  bit       mValid [16];
  int       mTag   [16];
  int       mData  [16];
  bit       s1V, s1LineV;
  int       s1Tag, s1Blk, s1Off;
  bit       eV, eH, eM, eT;
  int       eD;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mValid[i]) mValid[i] = 0;
      s1V = 0; eV = 0; eH = 0; eM = 0; eT = 0; eD = 0;
    end else begin
      eV = s1V;
      eH = s1V && tlbHit && s1LineV && (s1Tag == int'(tlbPpn));
      eT = s1V && !tlbHit;
      eM = s1V && tlbHit && !eH;
      eD = eH ? ((s1Blk >> (8*s1Off)) & 8'hFF) : 0;
      s1V = reqValid;
      if (reqValid) begin
        s1LineV = mValid[reqPageOff[5:2]];
        s1Tag   = mTag[reqPageOff[5:2]];
        s1Blk   = mData[reqPageOff[5:2]];
        s1Off   = int'(reqPageOff[1:0]);
      end
      if (refillValid) begin
        mValid[refillLine[3:0]] = 1;
        mTag[refillLine[3:0]]   = int'(refillLine[9:4]);
        mData[refillLine[3:0]]  = int'(refillData);
      end
    end
  end

  task automatic compareModel();
    checks++;
    if ({respValid, respHit, respMiss, respTlbMiss} !== {eV, eH, eM, eT} ||
        int'(respData) != eD) begin
      fails++;
      $display("FAIL %s: got v/h/m/t=%b%b%b%b data=%02h, expected %b%b%b%b data=%02h",
               curReq, respValid, respHit, respMiss, respTlbMiss, respData,
               eV, eH, eM, eT, eD[7:0]);
    end
  endtask

  task automatic cyc(input bit rv, input logic [5:0] po, input bit th,
                     input logic [5:0] pp, input bit fv, input logic [9:0] fl,
                     input logic [31:0] fd);
    @(posedge clk); #2;
    reqValid = rv; reqPageOff = po; tlbHit = th; tlbPpn = pp;
    refillValid = fv; refillLine = fl; refillData = fd;
    @(negedge clk);
    if (rstN) compareModel();
  endtask

  task automatic expectResp(input string req, input bit h, input bit m, input bit t,
                            input logic [7:0] d);
    checks++;
    if (respValid !== 1'b1 || respHit !== h || respMiss !== m || respTlbMiss !== t ||
        respData !== d) begin
      fails++;
      $display("FAIL %s: got v/h/m/t=%b%b%b%b data=%02h, expected 1%b%b%b data=%02h",
               req, respValid, respHit, respMiss, respTlbMiss, respData, h, m, t, d);
    end
  endtask

  task automatic refill(input logic [9:0] line, input logic [31:0] d);
    cyc(0, 0, 0, 0, 1, line, d);
  endtask

  task automatic lookupCheck(input string req, input logic [5:0] po, input logic [5:0] pp,
                             input bit th, input bit h, input bit m, input bit t,
                             input logic [7:0] d);
    curReq = req;
    cyc(1, po, 0, 0, 0, 0, 0);
    cyc(0, 0, th, pp, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    expectResp(req, h, m, t, d);
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R2: reset state
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (respValid !== 1'b0) begin
      fails++;
      $display("FAIL R2: got respValid=%b, expected 0", respValid);
    end
    // R2: first lookup of 0x354 misses
    lookupCheck("R2", 6'h14, 6'h0D, 1, 0, 1, 0, 8'h00);
    // R1, R7, R4: fill 0x354 (line 5, tag 0x0D) and hit each byte
    curReq = "R7";
    refill({6'h0D, 4'd5}, 32'hA1B2C336);
    lookupCheck("R1", 6'h14, 6'h0D, 1, 1, 0, 0, 8'h36);
    lookupCheck("R4", 6'h17, 6'h0D, 1, 1, 0, 0, 8'hA1);
    lookupCheck("R4", 6'h15, 6'h0D, 1, 1, 0, 0, 8'hC3);
    // R5: line 8 holds tag 0x24, request 0xA20 with tag 0x28
    curReq = "R5";
    refill({6'h24, 4'd8}, 32'h11223344);
    lookupCheck("R5", 6'h20, 6'h28, 1, 0, 1, 0, 8'h00);
    // R7: replace line 8 with tag 0x28
    curReq = "R7";
    refill({6'h28, 4'd8}, 32'h55667788);
    lookupCheck("R7", 6'h20, 6'h28, 1, 1, 0, 0, 8'h88);
    lookupCheck("R1", 6'h22, 6'h28, 1, 1, 0, 0, 8'h66);
    // R6: TLB miss on a matching line
    lookupCheck("R6", 6'h14, 6'h0D, 0, 0, 0, 1, 8'h00);
    // R9: back-to-back lookups, responses in order
    curReq = "R9";
    cyc(1, 6'h14, 0, 0, 0, 0, 0);
    cyc(1, 6'h20, 1, 6'h0D, 0, 0, 0);
    cyc(1, 6'h20, 1, 6'h28, 0, 0, 0);
    expectResp("R9", 1, 0, 0, 8'h36);
    cyc(0, 0, 1, 6'h3F, 0, 0, 0);
    expectResp("R9", 1, 0, 0, 8'h88);
    cyc(0, 0, 0, 0, 0, 0, 0);
    expectResp("R9", 0, 1, 0, 8'h00);
    // R10: refill line 3 in the same cycle as a lookup of line 3
    curReq = "R10";
    cyc(1, 6'h0C, 0, 0, 1, {6'h07, 4'd3}, 32'hDEADBE5A);
    cyc(1, 6'h0C, 1, 6'h07, 0, 0, 0);
    cyc(0, 0, 1, 6'h07, 0, 0, 0);
    expectResp("R10", 0, 1, 0, 8'h00);
    cyc(0, 0, 0, 0, 0, 0, 0);
    expectResp("R10", 1, 0, 0, 8'h5A);
    // R8: random mix compared with the model every cycle
    curReq = "R8";
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom;
      cyc(r[0], r[6:1], r[10:8] != 3'd0, {4'd0, r[12:11]}, r[13] & r[14],
          {4'd0, r[16:15], r[20:17]}, $urandom);
    end
    repeat (3) cyc(0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule